// File: doc/BRIEF.md
# Odd-Weight-Column SECDED Codec for 32-Bit Words

This block protects each 32-bit word held in a storage array with seven check bits, so every stored word is 39 bits wide. On a write, the encoder turns the incoming data word into a 39-bit codeword that goes into the array. On a read, the decoder takes the 39-bit codeword from the array and recomputes the seven check bits. It compares them with the stored ones to get a syndrome. From the syndrome it corrects any single flipped bit, in the data field or in the check field, and it reports any two flipped bits as uncorrectable.

Every column of the parity-check matrix has an odd number of ones, and the total number of ones is kept as low as it can be. Each check bit is the XOR of a subset of the data bits. Double-error detection therefore needs no extra overall-parity bit. A single error always gives an odd-weight syndrome, and two errors always give an even-weight one. Both paths are pure XOR trees. A parameter chooses whether all outputs leave through one register stage or straight from the logic.

Top module: `secded_codec`

## Requirements
- R1: The codeword places the data word in bits 31:0 and the check bits in bits 38:32. Check bit j (codeword bit 32+j) is the XOR of every data bit i whose column has bit j set. The column of data bit i is the i-th smallest 7-bit value that has exactly three ones, counting from i = 0 (7, 11, 13, 14, 19, ...).
- R2: When the syndrome is zero, the read data equals codeword bits 31:0 and both flags are low. The syndrome is the recomputed check bits XOR the received check bits 38:32.
- R3: When exactly one data bit i is flipped in a valid codeword, the read data equals the original data word. The corrected flag is high, the uncorrectable flag is low, and the syndrome equals the column of bit i.
- R4: When exactly one check bit 32+j is flipped, the syndrome is 1<<j and the corrected flag is high. The read data equals codeword bits 31:0, unmodified.
- R5: When any two codeword bits are flipped, the syndrome is nonzero with even weight. The uncorrectable flag is high, the corrected flag is low, and the read data equals the received bits 31:0.
- R6: A nonzero odd-weight syndrome that matches no column raises the uncorrectable flag and passes bits 31:0 through unchanged. Such syndromes are weight 5, weight 7, or the three unused weight-3 values 100, 104 and 112.
- R7: With OUT_REG = 1, every output reflects the inputs sampled at the previous rising clock edge. A synchronous active-high reset drives all outputs to zero.
- R8: The corrected flag and the uncorrectable flag are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset |
| wr_data | input | 32 | Data word to encode |
| wr_code | output | 39 | Encoded codeword for the array |
| rd_code | input | 39 | Codeword read back from the array |
| rd_data | output | 32 | Corrected data word |
| rd_corrected | output | 1 | A single-bit error was found and repaired |
| rd_uncorrectable | output | 1 | An error that cannot be corrected was found |
| rd_syndrome | output | 7 | Syndrome of the read codeword |

## Verification
The bench goes after every one of the 39 single-bit positions on a set of data words. A wrong column in the encoder or the matcher shows up there as a miscorrected bit, or as a good bit that gets flipped. Check-bit flips get their own checks, because a decoder that ran the flip logic across all 39 bits would damage the data output. All pairs of flips on several words confirm that no double error is taken for a single one. Syndromes that have odd weight but match no column, from three and from five flipped check bits, catch a decoder that treats any odd syndrome as correctable.

// File: rtl/secded_pkg.sv
package secded_pkg;

    localparam int DATA_W = 32;
    localparam int CHK_W  = 7;
    localparam int CODE_W = DATA_W + CHK_W;
    localparam int COL_WT = 3;

    typedef logic [DATA_W-1:0] data_t;
    typedef logic [CHK_W-1:0]  chk_t;
    typedef logic [CODE_W-1:0] code_t;

    typedef struct packed {
        data_t data;
        logic  corrected;
        logic  uncorrectable;
        chk_t  syndrome;
    } rd_result_t;

    // i-th smallest CHK_W-bit value with COL_WT ones
    function automatic chk_t data_column(input int idx);
        int   seen;
        chk_t col;
        chk_t cand;
        seen = 0;
        col  = '0;
        for (int v = 0; v < (1 << CHK_W); v++) begin
            cand = chk_t'(v);
            if ($countones(cand) == COL_WT) begin
                if (seen == idx) col = cand;
                seen++;
            end
        end
        return col;
    endfunction

    // data bits feeding check bit 'row'
    function automatic data_t row_mask(input int row);
        data_t m;
        chk_t  c;
        m = '0;
        for (int i = 0; i < DATA_W; i++) begin
            c    = data_column(i);
            m[i] = c[row];
        end
        return m;
    endfunction

endpackage

// File: rtl/secded_encoder.sv
module secded_encoder
    import secded_pkg::*;
(
    input  data_t data_i,
    output chk_t  check_o
);
    for (genvar gj = 0; gj < CHK_W; gj++) begin : g_row
        localparam data_t MASK = row_mask(gj);
        assign check_o[gj] = ^(data_i & MASK);
    end
endmodule

// File: rtl/secded_syndrome.sv
module secded_syndrome
    import secded_pkg::*;
(
    input  code_t code_i,
    output chk_t  syn_o
);
    chk_t recomputed;

    secded_encoder u_recompute (
        .data_i  (code_i[DATA_W-1:0]),
        .check_o (recomputed)
    );

    assign syn_o = recomputed ^ code_i[CODE_W-1:DATA_W];
endmodule

// File: rtl/secded_corrector.sv
module secded_corrector
    import secded_pkg::*;
(
    input  code_t      code_i,
    input  chk_t       syn_i,
    output rd_result_t res_o
);
    data_t flip;
    logic  check_hit;
    logic  hit;

    for (genvar gi = 0; gi < DATA_W; gi++) begin : g_match
        localparam chk_t COL = data_column(gi);
        assign flip[gi] = (syn_i == COL);
    end

    always_comb begin
        check_hit           = $onehot(syn_i);
        hit                 = (|flip) | check_hit;
        res_o.data          = code_i[DATA_W-1:0] ^ flip;
        res_o.corrected     = hit;
        res_o.uncorrectable = (syn_i != '0) && !hit;
        res_o.syndrome      = syn_i;
    end
endmodule

// File: rtl/secded_codec.sv
module secded_codec
    import secded_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [DATA_W-1:0]    wr_data,
    output logic [CODE_W-1:0]    wr_code,
    input  logic [CODE_W-1:0]    rd_code,
    output logic [DATA_W-1:0]    rd_data,
    output logic                 rd_corrected,
    output logic                 rd_uncorrectable,
    output logic [CHK_W-1:0]     rd_syndrome
);
    chk_t       enc_check;
    code_t      enc_code;
    chk_t       syn;
    rd_result_t dec;

    secded_encoder u_enc (
        .data_i  (wr_data),
        .check_o (enc_check)
    );

    assign enc_code = {enc_check, wr_data};

    secded_syndrome u_syn (
        .code_i (rd_code),
        .syn_o  (syn)
    );

    secded_corrector u_cor (
        .code_i (rd_code),
        .syn_i  (syn),
        .res_o  (dec)
    );

    if (OUT_REG) begin : g_reg
        code_t      code_q;
        rd_result_t res_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                code_q <= '0;
                res_q  <= '0;
            end else begin
                code_q <= enc_code;
                res_q  <= dec;
            end
        end

        assign wr_code          = code_q;
        assign rd_data          = res_q.data;
        assign rd_corrected     = res_q.corrected;
        assign rd_uncorrectable = res_q.uncorrectable;
        assign rd_syndrome      = res_q.syndrome;

        AST_ENC_DATA_FIELD: assert property (@(posedge clk) disable iff (rst)
            !$past(rst) |-> wr_code[DATA_W-1:0] == $past(wr_data)); // R1
        AST_CHK_ERR_KEEPS_DATA: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && $onehot(rd_syndrome)) |-> rd_data == $past(rd_code[DATA_W-1:0])); // R4
        AST_UNCORR_PASSES: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && rd_uncorrectable) |-> rd_data == $past(rd_code[DATA_W-1:0])); // R6
    end else begin : g_comb
        assign wr_code          = enc_code;
        assign rd_data          = dec.data;
        assign rd_corrected     = dec.corrected;
        assign rd_uncorrectable = dec.uncorrectable;
        assign rd_syndrome      = dec.syndrome;
    end

    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(rd_corrected && rd_uncorrectable)); // R8
    AST_ZERO_SYN_CLEAN: assert property (@(posedge clk) disable iff (rst)
        (rd_syndrome == '0) |-> (!rd_corrected && !rd_uncorrectable)); // R2
    AST_EVEN_SYN_UNCORR: assert property (@(posedge clk) disable iff (rst)
        ((rd_syndrome != '0) && ($countones(rd_syndrome) % 2 == 0)) |-> rd_uncorrectable); // R5
    AST_ONEHOT_SYN_CORR: assert property (@(posedge clk) disable iff (rst)
        $onehot(rd_syndrome) |-> rd_corrected); // R4
endmodule

// File: tb/secded_codec_bench.sv
`timescale 1ns/1ps
module secded_codec_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] wr_data = '0;
    logic [38:0] wr_code;
    logic [38:0] rd_code = '0;
    logic [31:0] rd_data;
    logic        rd_corrected;
    logic        rd_uncorrectable;
    logic [6:0]  rd_syndrome;

    int checks = 0;
    int failures = 0;
    logic [31:0] pats [20];

    always #2.5 clk = ~clk;

    secded_codec u_secded_codec (
        .clk              (clk),
        .rst              (rst),
        .wr_data          (wr_data),
        .wr_code          (wr_code),
        .rd_code          (rd_code),
        .rd_data          (rd_data),
        .rd_corrected     (rd_corrected),
        .rd_uncorrectable (rd_uncorrectable),
        .rd_syndrome      (rd_syndrome)
    );

    function automatic logic [6:0] exp_col(input int idx);
        int n = 0;
        logic [6:0] r = '0;
        for (int v = 0; v < 128; v++) begin
            int w = (v & 1) + ((v >> 1) & 1) + ((v >> 2) & 1) + ((v >> 3) & 1)
                  + ((v >> 4) & 1) + ((v >> 5) & 1) + ((v >> 6) & 1);
            if (w == 3) begin
                if (n == idx) r = 7'(v);
                n++;
            end
        end
        return r;
    endfunction

    function automatic logic [38:0] exp_code(input logic [31:0] d);
        logic [6:0] c = '0;
        for (int i = 0; i < 32; i++) if (d[i]) c ^= exp_col(i);
        return {c, d};
    endfunction

    function automatic logic [6:0] exp_syn(input logic [38:0] mask);
        logic [6:0] s = '0;
        for (int i = 0; i < 32; i++) if (mask[i]) s ^= exp_col(i);
        for (int j = 0; j < 7; j++) if (mask[32+j]) s[j] = ~s[j];
        return s;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input logic [31:0] d, input logic [38:0] rc);
        wr_data = d;
        rd_code = rc;
        @(posedge clk);
        #1;
    endtask

    task automatic read_single(input logic [31:0] d, input int pos);
        logic [38:0] good = exp_code(d);
        logic [38:0] mask = 39'd1 << pos;
        step(d, good ^ mask);
        if (pos < 32) begin
            chk("R3 data", 64'(rd_data), 64'(d));
            chk("R3 corrected", 64'(rd_corrected), 64'd1);
            chk("R3 uncorrectable", 64'(rd_uncorrectable), 64'd0);
            chk("R3 syndrome", 64'(rd_syndrome), 64'(exp_col(pos)));
        end else begin
            chk("R4 data", 64'(rd_data), 64'(d));
            chk("R4 corrected", 64'(rd_corrected), 64'd1);
            chk("R4 syndrome", 64'(rd_syndrome), 64'(7'd1 << (pos - 32)));
        end
        chk("R8 flags", 64'(rd_corrected & rd_uncorrectable), 64'd0);
    endtask

    task automatic read_double(input logic [31:0] d, input int a, input int b);
        logic [38:0] mask = (39'd1 << a) | (39'd1 << b);
        logic [38:0] bad = exp_code(d) ^ mask;
        step(d, bad);
        chk("R5 uncorrectable", 64'(rd_uncorrectable), 64'd1);
        chk("R5 corrected", 64'(rd_corrected), 64'd0);
        chk("R5 data", 64'(rd_data), 64'(bad[31:0]));
        chk("R5 syndrome", 64'(rd_syndrome), 64'(exp_syn(mask)));
    endtask

    initial begin : watchdog
        #1000000;
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        logic [31:0] x;
        logic [38:0] bad;
        pats[0] = 32'h0000_0000; pats[1] = 32'hFFFF_FFFF;
        pats[2] = 32'hAAAA_AAAA; pats[3] = 32'h5555_5555;
        pats[4] = 32'h0000_0001; pats[5] = 32'h8000_0000;
        x = 32'h1234_5679;
        for (int k = 6; k < 20; k++) begin
            x ^= x << 13; x ^= x >> 17; x ^= x << 5;
            pats[k] = x;
        end

        wr_data = 32'hDEAD_BEEF;
        rd_code = 39'h7F_FFFF_FFFF;
        repeat (3) @(posedge clk);
        #1;
        chk("R7 reset code", 64'(wr_code), 64'd0);
        chk("R7 reset data", 64'(rd_data), 64'd0);
        chk("R7 reset flags", 64'({rd_corrected, rd_uncorrectable, rd_syndrome}), 64'd0);
        rst = 1'b0;

        // latency: outputs hold until the next edge
        step(32'h0F0F_0F0F, exp_code(32'h0F0F_0F0F));
        wr_data = 32'h1111_2222;
        rd_code = exp_code(32'h1111_2222);
        #1;
        chk("R7 hold code", 64'(wr_code), 64'(exp_code(32'h0F0F_0F0F)));
        chk("R7 hold data", 64'(rd_data), 64'(32'h0F0F_0F0F));
        @(posedge clk);
        #1;
        chk("R7 one-cycle data", 64'(rd_data), 64'(32'h1111_2222));

        for (int p = 0; p < 20; p++) begin
            step(pats[p], exp_code(pats[p]));
            chk("R1 codeword", 64'(wr_code), 64'(exp_code(pats[p])));
            chk("R2 data", 64'(rd_data), 64'(pats[p]));
            chk("R2 flags", 64'({rd_corrected, rd_uncorrectable}), 64'd0);
            chk("R2 syndrome", 64'(rd_syndrome), 64'd0);
            for (int pos = 0; pos < 39; pos++) read_single(pats[p], pos);
        end

        for (int p = 0; p < 3; p++)
            for (int a = 0; a < 39; a++)
                for (int b = a + 1; b < 39; b++) read_double(pats[p], a, b);
        for (int p = 3; p < 20; p++)
            for (int k = 0; k < 20; k++) read_double(pats[p], (k * 7 + p) % 39, (k * 7 + p + 1 + (k % 37)) % 39);

        // odd syndrome with no matching column: unused weight-3 and weight-5
        for (int p = 0; p < 20; p++) begin
            bad = exp_code(pats[p]) ^ {7'h70, 32'h0};
            step(pats[p], bad);
            chk("R6 uncorrectable w3", 64'(rd_uncorrectable), 64'd1);
            chk("R6 data w3", 64'(rd_data), 64'(bad[31:0]));
            chk("R6 syndrome w3", 64'(rd_syndrome), 64'h70);
            bad = exp_code(pats[p]) ^ {7'h1F, 32'h0};
            step(pats[p], bad);
            chk("R6 uncorrectable w5", 64'(rd_uncorrectable), 64'd1);
            chk("R6 corrected w5", 64'(rd_corrected), 64'd0);
            chk("R6 data w5", 64'(rd_data), 64'(bad[31:0]));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule